// File: doc/BRIEF.md
# Marker-Bit Asynchronous Serial Transmitter

This block turns a byte into a ten-bit asynchronous frame on a single serial line: a low start bit, the eight data bits beginning with the least significant one, and a high stop bit. Bit timing does not come from the write. An external tick arriving at sixteen times the bit rate advances a free-running divide-by-sixteen counter. Every wrap of that counter (a "rollover") marks a bit boundary, and the line changes only at those boundaries.

A write strobe loads the byte into a shift register one bit wider than the data. The extra top position holds a single 1, called the marker. Each data bit time shifts the register right and fills it with zeros. The block knows the frame is ending when everything above the output bit is zero except a 1 directly beside it. At that boundary it makes one last shift, stops driving data and raises a done flag. The flag stays high until a clear input drops it. A write that arrives while a frame is waiting or in flight has no effect.

Top module: `async_marker_tx`

## Requirements
- R1: Reset and idle state. Out of reset and whenever no frame is waiting or in flight, the serial line `txd` is 1 and the done flag `ti` is 0 after reset.
- R2: Frame format. After an accepted write, the line carries 0 for one bit time, then `wr_data[0]` through `wr_data[7]` with one bit per bit time, then 1. The line stays at 1 for at least one full bit time before any following start bit.
- R3: Bit boundaries. A rollover is the clock edge at which the 16th, 32nd, 48th and so on `baud_tick` counted since reset is sampled. A write never restarts this count. `txd` changes only in the cycle after a rollover edge.
- R4: Start alignment. The start bit appears after the first rollover edge that follows the write edge. A rollover in the same cycle as the write does not count. Until that rollover, `txd` stays 1.
- R5: Done flag. `ti` rises after the tenth rollover edge that follows the write edge. It is 0 before that point, provided it was cleared before the write. Once set, it stays 1 while `ti_clr` is low.
- R6: Flag clear. When `ti_clr` is 1 at a clock edge and no frame completes at that same edge, `ti` is 0 after that edge. A frame that completes at the same edge keeps `ti` set, because setting wins over clearing.
- R7: Busy writes ignored. A `wr_stb` pulse is ignored if it arrives at any edge from the accepted write up to, but not including, the edge that sets `ti`. Such a pulse changes neither the frame being sent nor the line after it, and it does not start a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_stb | input | 1 | Buffer-write strobe |
| wr_data | input | DATA_W | Byte to send (bit 0 goes first) |
| ti_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idles at 1 |
| ti | output | 1 | Done flag, set when a frame's last shift occurs |

## Verification
Every result of this block falls due one cycle after a rollover edge. The start bit is due after the first rollover that follows the write, each later bit after the next rollover, and `ti` after the tenth. Only the clear of `ti` is tied to a different edge: it is due one cycle after the `ti_clr` edge. The bench keeps its own count of baud ticks and rollovers, taken from the ticks it drives. It samples `txd` and `ti` on the falling edge just after each counted rollover, and it also watches the line on every falling edge between rollovers to confirm that nothing moves there. Writes are placed at several offsets from a rollover, including right at the end of a frame, and extra writes are injected while the block is waiting and while it is sending.

// File: rtl/amtx_pkg.sv
package amtx_pkg;
   // Transmit phases: waiting for a request, request pending until the next
   // rollover, start bit on the line, data/marker bits on the line.
   typedef enum logic [1:0] {
      TXP_IDLE  = 2'd0,
      TXP_WAIT  = 2'd1,
      TXP_START = 2'd2,
      TXP_DATA  = 2'd3
   } txp_phase_e;
endpackage

// File: rtl/amtx_bit_timer.sv
module amtx_bit_timer #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   output logic bit_tick
);
   localparam int  CNT_W  = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam bit  IS_P2  = ((1 << CNT_W) == OVERSAMPLE);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("amtx_bit_timer: OVERSAMPLE must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap     = (cnt_q == LAST);
   assign bit_tick = baud_tick && wrap;

   if (IS_P2) begin : g_natural_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)         cnt_q <= '0;
         else if (baud_tick) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_compare_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)         cnt_q <= '0;
         else if (baud_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/amtx_shifter.sv
module amtx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              shift,
   output logic              out_bit,
   output logic              at_last,
   output logic [DATA_W:0]   sr_q
);
   localparam int SR_W = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_w
      $error("amtx_shifter: DATA_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     sr_q <= '1;
      else if (load)  sr_q <= {1'b1, data};
      else if (shift) sr_q <= {1'b0, sr_q[SR_W-1:1]};
   end

   assign out_bit = sr_q[0];
   // Only the marker is left above the output bit: last data bit on the line.
   assign at_last = (sr_q[SR_W-1:1] == (SR_W-1)'(1));
endmodule

// File: rtl/amtx_ctrl.sv
module amtx_ctrl
   import amtx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic       wr_stb,
   input  logic       ti_clr,
   input  logic       at_last,
   output logic       load,
   output logic       shift,
   output txp_phase_e phase,
   output logic       ti
);
   logic ti_set;

   assign load   = (phase == TXP_IDLE) && wr_stb;
   assign shift  = (phase == TXP_DATA) && bit_tick;
   assign ti_set = shift && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= TXP_IDLE;
         ti    <= 1'b0;
      end else begin
         if (ti_set)      ti <= 1'b1;
         else if (ti_clr) ti <= 1'b0;
         unique case (phase)
            TXP_IDLE:  if (wr_stb)            phase <= TXP_WAIT;
            TXP_WAIT:  if (bit_tick)          phase <= TXP_START;
            TXP_START: if (bit_tick)          phase <= TXP_DATA;
            TXP_DATA:  if (bit_tick && at_last) phase <= TXP_IDLE;
            default:                          phase <= TXP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/async_marker_tx.sv
module async_marker_tx
   import amtx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ti_clr,
   output logic              txd,
   output logic              ti
);
   logic            bit_tick;
   logic            load;
   logic            shift;
   logic            out_bit;
   logic            at_last;
   logic [DATA_W:0] sr_q;
   logic            busy;
   txp_phase_e      phase;

   amtx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .bit_tick  (bit_tick)
   );

   amtx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .data    (wr_data),
      .shift   (shift),
      .out_bit (out_bit),
      .at_last (at_last),
      .sr_q    (sr_q)
   );

   amtx_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .wr_stb   (wr_stb),
      .ti_clr   (ti_clr),
      .at_last  (at_last),
      .load     (load),
      .shift    (shift),
      .phase    (phase),
      .ti       (ti)
   );

   assign busy = (phase != TXP_IDLE);

   always_comb begin
      unique case (phase)
         TXP_START: txd = 1'b0;
         TXP_DATA:  txd = out_bit;
         default:   txd = 1'b1;
      endcase
   end
endmodule

// File: rtl/amtx_checker.sv
module amtx_checker #(
   parameter int DATA_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_stb,
   input logic            ti_clr,
   input logic            txd,
   input logic            ti,
   input logic            bit_tick,
   input logic            busy,
   input logic [DATA_W:0] sr_q
);
   // R1: nothing waiting or sending keeps the line high
   p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R3: the line only moves right after a rollover
   p_line_on_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));

   // R4: a start bit begins only after a rollover edge
   p_start_on_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txd) |-> $past(bit_tick));

   // R5: the flag rises at a rollover with the line back at 1
   p_ti_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ti) |-> ($past(bit_tick) && txd));

   // R5: the flag holds until cleared
   p_ti_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ti && !ti_clr) |=> ti);

   // R6: a clear away from a rollover drops the flag
   p_ti_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ti_clr && !bit_tick) |=> !ti);

   // R7: a write while busy leaves the shift register alone
   p_busy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb && !bit_tick) |=> $stable(sr_q));
endmodule

bind async_marker_tx amtx_checker #(.DATA_W(DATA_W)) u_amtx_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .ti_clr   (ti_clr),
   .txd      (txd),
   .ti       (ti),
   .bit_tick (bit_tick),
   .busy     (busy),
   .sr_q     (sr_q)
);

// File: tb/async_marker_tx_bench.sv
`timescale 1ns/1ps
module async_marker_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       ti_clr = 1'b0;
   logic       txd;
   logic       ti;

   int tests = 0;
   int fails = 0;
   int rolls = 0;
   logic [3:0] tick_idx = 4'd0;
   int baud_div = 0;

   always #2 clk = ~clk;

   async_marker_tx u_async_marker_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .ti_clr    (ti_clr),
      .txd       (txd),
      .ti        (ti)
   );

   // Baud tick: one cycle in three, driven away from the active edge.
   always @(negedge clk) begin
      baud_tick <= (baud_div == 0);
      baud_div  <= (baud_div == 2) ? 0 : baud_div + 1;
   end

   // Independent model of rollovers (R3): every 16th sampled tick since reset.
   always @(posedge clk) begin
      if (!rst_n) begin
         tick_idx <= 4'd0;
         rolls    <= 0;
      end else if (baud_tick) begin
         if (tick_idx == 4'd15) rolls <= rolls + 1;
         tick_idx <= tick_idx + 4'd1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(txd === 1'b1, "R1 line high after reset", int'(txd), 1);
      chk(ti === 1'b0, "R1 flag low after reset", int'(ti), 0);
   endtask

   // skew < 0: write at once; otherwise align to a rollover and wait skew cycles.
   // intrude >= 0: inject a junk write after that many rollovers (R7).
   task automatic t_frame(input logic [7:0] d, input int skew, input int intrude);
      int  r0;
      bit  moved;
      logic prev, expv;
      if (skew >= 0) begin
         r0 = rolls;
         do @(negedge clk); while (rolls == r0);
         repeat (skew) @(negedge clk);
      end
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      r0 = rolls;
      chk(txd === 1'b1, "R4 line still high right after write", int'(txd), 1);
      if (intrude == 0) begin
         wr_stb = 1'b1; wr_data = ~d;
         @(negedge clk);
         wr_stb = 1'b0;
      end
      prev = 1'b1;
      for (int k = 1; k <= 10; k++) begin
         moved = 1'b0;
         while (rolls < r0 + k) begin
            if (txd !== prev) moved = 1'b1;
            @(negedge clk);
         end
         if (k == 1)       expv = 1'b0;
         else if (k == 10) expv = 1'b1;
         else              expv = d[k-2];
         chk(!moved, $sformatf("R3 line moved between rollovers before bit %0d", k), int'(moved), 0);
         chk(txd === expv, $sformatf("R2/R4 line after rollover %0d data %0h", k, d), int'(txd), int'(expv));
         if (k < 10) chk(ti === 1'b0, $sformatf("R5 flag early at rollover %0d", k), int'(ti), 0);
         else        chk(ti === 1'b1, "R5 flag at tenth rollover", int'(ti), 1);
         prev = expv;
         if (intrude == k) begin
            wr_stb = 1'b1; wr_data = ~d;
            @(negedge clk);
            wr_stb = 1'b0;
         end
      end
   endtask

   task automatic t_quiet(input int n);
      int r0;
      bit moved;
      r0 = rolls;
      for (int k = 1; k <= n; k++) begin
         moved = 1'b0;
         while (rolls < r0 + k) begin
            if (txd !== 1'b1) moved = 1'b1;
            @(negedge clk);
         end
         if (txd !== 1'b1) moved = 1'b1;
         chk(!moved, "R7 no frame from ignored write", int'(moved), 0);
      end
   endtask

   task automatic t_ti_clear();
      chk(ti === 1'b1, "R5 flag set before clear", int'(ti), 1);
      repeat (3) @(negedge clk);
      chk(ti === 1'b1, "R5 flag holds without clear", int'(ti), 1);
      ti_clr = 1'b1;
      @(negedge clk);
      ti_clr = 1'b0;
      chk(ti === 1'b0, "R6 flag cleared one cycle after clear", int'(ti), 0);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_frame(8'hA5, 0, -1);
      t_ti_clear();
      t_frame(8'h3C, 17, -1);
      t_ti_clear();
      t_frame(8'h00, 5, 0);
      t_quiet(2);
      t_ti_clear();
      t_frame(8'hFF, 30, 4);
      t_quiet(2);
      t_ti_clear();
      t_frame(8'h6E, 2, 9);
      t_ti_clear();
      t_frame(8'h81, -1, -1);
      t_ti_clear();
      t_quiet(1);
      chk(ti === 1'b0, "R1 flag stays low while idle", int'(ti), 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule